// File: doc/BRIEF.md
# Dual-Port Synchronous Static RAM with Selectable Read Path

This block is a true dual-port static RAM. Two independent access ports, named A and B, share one array of 18-bit words. Each word is split into two 9-bit byte lanes. Each port has:

- a select pair: one active-low input and one active-high input, both of which must be asserted;
- a read/write control;
- a separate active-low enable for each lane;
- an active-low address load strobe;
- an active-low output enable.

Every control is registered on the rising edge of the shared clock. The only exception is the output enable, which gates the outputs directly.

A parameter chooses the read path. In flow-through mode, the word addressed at an edge appears during the following cycle. In pipelined mode, it passes through one more output register and appears a cycle later.

Each port presents its read data together with one drive flag per lane. A system can therefore place several devices on a shared bus for depth expansion. Any lane that is not driving shows zero on its data bits. A port that is deselected, writing or disabled lets go of the bus, so another device can drive in the next cycle.

Top module: `dpram_sync`

## Requirements
- R1: A port accesses the array only when its active-low select is 0 and its active-high select is 1 at the rising edge. Otherwise nothing is written and that port drives nothing in the cycle where a read would have appeared.
- R2: With the load strobe low, the access address is the address input. With the strobe high, the port reuses the last address it used, which is zero after reset.
- R3: In flow-through mode, a read sampled at edge N drives its data from edge N until edge N+1.
- R4: In pipelined mode, a read sampled at edge N drives its data from edge N+1 until edge N+2. The drive flags follow the controls registered one cycle earlier.
- R5: Lane 0 is bits 8:0 and is enabled by the lower-lane enable. Lane 1 is bits 17:9 and is enabled by the upper-lane enable. Both enables are active low. A write changes only the enabled lanes, and a read drives only the enabled lanes.
- R6: While a port's output enable is high, both of its drive flags are 0 and its data output is zero. This takes effect in the same cycle and leaves no lasting effect.
- R7: A write access never makes the writing port drive.
- R8: A write on one port at edge N is invisible to a read of the same address on the other port at edge N. It is visible to such a read at edge N+1.
- R9: When both ports write the same address at the same edge, port A's data wins in every lane that port A writes. Port B's data lands in the other lanes that port B writes.
- R10: In pipelined mode, a read followed at the next edge by a write on the same port still drives the read data during the write cycle, unless the output enable is high.
- R11: After reset, every drive flag is 0 and every data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| a_sel_n | input | 1 | Port A select, active low |
| a_sel | input | 1 | Port A select, active high |
| a_read | input | 1 | Port A: 1 = read, 0 = write |
| a_hi_n | input | 1 | Port A upper-lane enable, active low |
| a_lo_n | input | 1 | Port A lower-lane enable, active low |
| a_load_n | input | 1 | Port A address load strobe, active low |
| a_out_en_n | input | 1 | Port A output enable, active low |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | 18 | Port A write data |
| a_rdata | output | 18 | Port A read data, zero in lanes that are not driving |
| a_drv | output | 2 | Port A drive flag per lane |
| b_sel_n | input | 1 | Port B select, active low |
| b_sel | input | 1 | Port B select, active high |
| b_read | input | 1 | Port B: 1 = read, 0 = write |
| b_hi_n | input | 1 | Port B upper-lane enable, active low |
| b_lo_n | input | 1 | Port B lower-lane enable, active low |
| b_load_n | input | 1 | Port B address load strobe, active low |
| b_out_en_n | input | 1 | Port B output enable, active low |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | 18 | Port B write data |
| b_rdata | output | 18 | Port B read data, zero in lanes that are not driving |
| b_drv | output | 2 | Port B drive flag per lane |

## Verification
The bench builds two copies of the block, both with ADDR_W = 8. One copy uses the pipelined read path and the other uses flow-through, and both receive the same stimulus. A 256-word array can be filled completely in 128 cycles, with both ports writing. As a result, every later read targets a known word. The paired build lets the one-cycle latency difference, the pipelined read-before-write turnaround and the same-edge cross-port ordering all be checked against one reference model at the same time.

// File: rtl/dpram_pkg.sv
// Package: shared read-path selector for the dual-port RAM.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package dpram_pkg;
    typedef enum logic {
        RD_FLOW = 1'b0,   // data one edge after the access
        RD_PIPE = 1'b1    // data two edges after the access
    } rd_mode_e;
endpackage

// File: rtl/dpram_port_ctrl.sv
// Module: per-port control decode and address hold register.
// What it does: it forms the access address from the load strobe and derives
// the per-lane read and write requests from the select pair.
// Assumes: every input is synchronous to clk. The lane enables are active low,
// with bit 0 as the lower lane.
module dpram_port_ctrl #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              read,
    input  logic              load_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  wr_lanes,
    output logic [LANES-1:0]  rd_lanes,
    output logic [ADDR_W-1:0] hold_addr
);
    logic [ADDR_W-1:0] hold_q;
    logic              picked;

    // Purpose: the port is active only with both selects asserted.
    always_comb begin
        picked   = !sel_n && sel;
        acc_addr = load_n ? hold_q : addr;
        wr_lanes = (picked && !read) ? ~lane_n : '0;
        rd_lanes = (picked && read)  ? ~lane_n : '0;
    end

    // Purpose: keep the last used address for cycles with the strobe high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= acc_addr;
        end
    end

    assign hold_addr = hold_q;
endmodule

// File: rtl/dpram_array.sv
// Module: storage array with two lane-masked write ports and two registered
// read ports.
// What it does: it captures each port's word at the edge. Writes made at the
// same edge are seen one edge later. Port A's write is applied last, so it
// takes precedence in a lane that both ports write.
// Assumes: a single clock for both ports. The contents are not reset.
module dpram_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 9
) (
    input  logic                      clk,
    input  logic [ADDR_W-1:0]         a_addr,
    input  logic [LANES-1:0]          a_wr_lanes,
    input  logic [LANES*LANE_W-1:0]   a_wdata,
    input  logic [ADDR_W-1:0]         b_addr,
    input  logic [LANES-1:0]          b_wr_lanes,
    input  logic [LANES*LANE_W-1:0]   b_wdata,
    output logic [LANES*LANE_W-1:0]   a_rword,
    output logic [LANES*LANE_W-1:0]   b_rword
);
    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned WORD_W = LANES * LANE_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Purpose: read the old contents and apply lane writes, port B first and A last.
    always_ff @(posedge clk) begin
        a_rword <= mem[a_addr];
        b_rword <= mem[b_addr];
        for (int l = 0; l < LANES; l++) begin
            if (b_wr_lanes[l]) begin
                mem[b_addr][l*LANE_W +: LANE_W] <= b_wdata[l*LANE_W +: LANE_W];
            end
            if (a_wr_lanes[l]) begin
                mem[a_addr][l*LANE_W +: LANE_W] <= a_wdata[l*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/dpram_read_path.sv
// Module: read output stage of one port.
// What it does: it registers the per-lane read-valid flags and, in pipelined
// mode, adds a second register stage for both the word and the flags. The
// output enable then gates the drive flags, and lanes that are not driving
// read as zero.
// Assumes: rword is already registered at the access edge.
module dpram_read_path
    import dpram_pkg::*;
#(
    parameter rd_mode_e    RD_MODE = RD_PIPE,
    parameter int unsigned LANES   = 2,
    parameter int unsigned LANE_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        rd_lanes,
    input  logic [LANES*LANE_W-1:0] rword,
    input  logic                    out_en_n,
    output logic [LANES-1:0]        drv,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int unsigned WORD_W = LANES * LANE_W;

    logic [LANES-1:0]  vld1_q;
    logic [LANES-1:0]  vld_out;
    logic [WORD_W-1:0] word_out;

    // Purpose: mark which lanes the read at the last edge returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld1_q <= '0;
        end else begin
            vld1_q <= rd_lanes;
        end
    end

    if (RD_MODE == RD_PIPE) begin : g_pipe
        logic [LANES-1:0]  vld2_q;
        logic [WORD_W-1:0] word2_q;

        // Purpose: extra output register stage for the pipelined read path.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld2_q  <= '0;
                word2_q <= '0;
            end else begin
                vld2_q  <= vld1_q;
                word2_q <= rword;
            end
        end
        assign vld_out  = vld2_q;
        assign word_out = word2_q;
    end else begin : g_flow
        assign vld_out  = vld1_q;
        assign word_out = rword;
    end

    assign drv = vld_out & {LANES{!out_en_n}};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rdata[l*LANE_W +: LANE_W] = drv[l] ? word_out[l*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/dpram_sync.sv
// Module: top level of the dual-port synchronous RAM.
// What it does: it joins two port control decoders, the shared array and two
// read output stages.
// Assumes: both ports run on clk. The word is 2 lanes of 9 bits.
module dpram_sync
    import dpram_pkg::*;
#(
    parameter rd_mode_e    RD_MODE = RD_PIPE,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel_n,
    input  logic              a_sel,
    input  logic              a_read,
    input  logic              a_hi_n,
    input  logic              a_lo_n,
    input  logic              a_load_n,
    input  logic              a_out_en_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [17:0]       a_wdata,
    output logic [17:0]       a_rdata,
    output logic [1:0]        a_drv,
    input  logic              b_sel_n,
    input  logic              b_sel,
    input  logic              b_read,
    input  logic              b_hi_n,
    input  logic              b_lo_n,
    input  logic              b_load_n,
    input  logic              b_out_en_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [17:0]       b_wdata,
    output logic [17:0]       b_rdata,
    output logic [1:0]        b_drv
);
    localparam int unsigned LANES  = 2;
    localparam int unsigned LANE_W = 9;

    logic [ADDR_W-1:0] a_acc_addr, b_acc_addr;
    logic [ADDR_W-1:0] a_hold_addr, b_hold_addr;
    logic [LANES-1:0]  a_wr_lanes, b_wr_lanes, a_rd_lanes, b_rd_lanes;
    logic [17:0]       a_rword, b_rword;

    dpram_port_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl_a (
        .clk(clk), .rst_n(rst_n), .sel_n(a_sel_n), .sel(a_sel), .read(a_read),
        .load_n(a_load_n), .lane_n({a_hi_n, a_lo_n}), .addr(a_addr),
        .acc_addr(a_acc_addr), .wr_lanes(a_wr_lanes), .rd_lanes(a_rd_lanes),
        .hold_addr(a_hold_addr)
    );

    dpram_port_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl_b (
        .clk(clk), .rst_n(rst_n), .sel_n(b_sel_n), .sel(b_sel), .read(b_read),
        .load_n(b_load_n), .lane_n({b_hi_n, b_lo_n}), .addr(b_addr),
        .acc_addr(b_acc_addr), .wr_lanes(b_wr_lanes), .rd_lanes(b_rd_lanes),
        .hold_addr(b_hold_addr)
    );

    dpram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk),
        .a_addr(a_acc_addr), .a_wr_lanes(a_wr_lanes), .a_wdata(a_wdata),
        .b_addr(b_acc_addr), .b_wr_lanes(b_wr_lanes), .b_wdata(b_wdata),
        .a_rword(a_rword), .b_rword(b_rword)
    );

    dpram_read_path #(.RD_MODE(RD_MODE), .LANES(LANES), .LANE_W(LANE_W)) u_rd_a (
        .clk(clk), .rst_n(rst_n), .rd_lanes(a_rd_lanes), .rword(a_rword),
        .out_en_n(a_out_en_n), .drv(a_drv), .rdata(a_rdata)
    );

    dpram_read_path #(.RD_MODE(RD_MODE), .LANES(LANES), .LANE_W(LANE_W)) u_rd_b (
        .clk(clk), .rst_n(rst_n), .rd_lanes(b_rd_lanes), .rword(b_rword),
        .out_en_n(b_out_en_n), .drv(b_drv), .rdata(b_rdata)
    );
endmodule

// File: rtl/dpram_sync_chk.sv
// Module: assertion checker, bound to every instance of dpram_sync.
// What it does: it checks latency, release, output-enable and hold-address rules.
// Assumes: it is attached by the bind statement at the end of this file.
module dpram_sync_chk
    import dpram_pkg::*;
#(
    parameter rd_mode_e    RD_MODE = RD_PIPE,
    parameter int unsigned ADDR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_sel_n,
    input logic              a_sel,
    input logic              a_read,
    input logic              a_lo_n,
    input logic              a_load_n,
    input logic              a_out_en_n,
    input logic [17:0]       a_rdata,
    input logic [1:0]        a_drv,
    input logic [ADDR_W-1:0] a_hold_addr,
    input logic              b_sel_n,
    input logic              b_sel,
    input logic              b_read,
    input logic              b_load_n,
    input logic [1:0]        b_drv,
    input logic [ADDR_W-1:0] b_hold_addr
);
    logic a_on, b_on;
    assign a_on = !a_sel_n && a_sel;
    assign b_on = !b_sel_n && b_sel;

    if (RD_MODE == RD_FLOW) begin : g_flow
        AST_FLOW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (a_on && a_read && !a_lo_n) |=> (a_drv[0] == !a_out_en_n)); // R3
        AST_DESELECT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            !a_on |=> (a_drv == 2'b00)); // R1
        AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (b_on && !b_read) |=> (b_drv == 2'b00)); // R7
    end else begin : g_pipe
        AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (a_on && a_read && !a_lo_n) |=> ##1 (a_drv[0] == !a_out_en_n)); // R4
        AST_DESELECT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            !a_on |=> ##1 (a_drv == 2'b00)); // R1
        AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (b_on && !b_read) |=> ##1 (b_drv == 2'b00)); // R7
    end

    AST_OE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        a_out_en_n |-> (a_drv == 2'b00 && a_rdata == 18'd0)); // R6
    AST_HOLD_ADDR_A: assert property (@(posedge clk) disable iff (!rst_n)
        a_load_n |=> $stable(a_hold_addr)); // R2
    AST_HOLD_ADDR_B: assert property (@(posedge clk) disable iff (!rst_n)
        b_load_n |=> $stable(b_hold_addr)); // R2
endmodule

bind dpram_sync dpram_sync_chk #(.RD_MODE(RD_MODE), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dpram_sync_tb_top.sv
// Bench: one pipelined copy and one flow-through copy receive the same stimulus.
// A driver task pushes the expected output of every cycle into scoreboard
// queues, and a monitor pops and compares them at each falling edge.
`timescale 1ns/100ps
module dpram_sync_tb_top;
    import dpram_pkg::*;

    typedef struct {
        int         due;
        logic [1:0] vld;
        logic [17:0] word;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_sel_n = 1'b1, a_sel = 1'b0, a_read = 1'b1, a_hi_n = 1'b0, a_lo_n = 1'b0;
    logic a_load_n = 1'b0, a_out_en_n = 1'b0;
    logic [7:0]  a_addr = '0;
    logic [17:0] a_wdata = '0;
    logic b_sel_n = 1'b1, b_sel = 1'b0, b_read = 1'b1, b_hi_n = 1'b0, b_lo_n = 1'b0;
    logic b_load_n = 1'b0, b_out_en_n = 1'b0;
    logic [7:0]  b_addr = '0;
    logic [17:0] b_wdata = '0;
    logic [17:0] p_a_rdata, p_b_rdata, f_a_rdata, f_b_rdata;
    logic [1:0]  p_a_drv, p_b_drv, f_a_drv, f_b_drv;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   edge_cnt = 0;
    int   coll_cnt = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;
    exp_t sbq [4][$];
    logic [17:0] ref_mem [256];
    logic [7:0]  ref_hold_a = '0, ref_hold_b = '0;

    always #2.5 clk = ~clk;

    dpram_sync #(.RD_MODE(RD_PIPE), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_sel_n(a_sel_n), .a_sel(a_sel), .a_read(a_read), .a_hi_n(a_hi_n), .a_lo_n(a_lo_n),
        .a_load_n(a_load_n), .a_out_en_n(a_out_en_n), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(p_a_rdata), .a_drv(p_a_drv),
        .b_sel_n(b_sel_n), .b_sel(b_sel), .b_read(b_read), .b_hi_n(b_hi_n), .b_lo_n(b_lo_n),
        .b_load_n(b_load_n), .b_out_en_n(b_out_en_n), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(p_b_rdata), .b_drv(p_b_drv)
    );

    dpram_sync #(.RD_MODE(RD_FLOW), .ADDR_W(8)) dut_ft_i (
        .clk(clk), .rst_n(rst_n),
        .a_sel_n(a_sel_n), .a_sel(a_sel), .a_read(a_read), .a_hi_n(a_hi_n), .a_lo_n(a_lo_n),
        .a_load_n(a_load_n), .a_out_en_n(a_out_en_n), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(f_a_rdata), .a_drv(f_a_drv),
        .b_sel_n(b_sel_n), .b_sel(b_sel), .b_read(b_read), .b_hi_n(b_hi_n), .b_lo_n(b_lo_n),
        .b_load_n(b_load_n), .b_out_en_n(b_out_en_n), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(f_b_rdata), .b_drv(f_b_drv)
    );

    // Purpose: count rising edges since reset release.
    always @(posedge clk) if (rst_n) edge_cnt <= edge_cnt + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [19:0] act, input logic [19:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Purpose: scoreboard monitor. Queue index = dev*2 + port, dev 0 pipelined, 1 flow-through.
    always @(negedge clk) begin
        if (mon_on) begin
            for (int q = 0; q < 4; q++) begin
                if (sbq[q].size() > 0 && sbq[q][0].due == edge_cnt) begin
                    exp_t        it;
                    logic [1:0]  ed;
                    logic [17:0] ex, od;
                    logic [1:0]  ov;
                    logic        oe_n;
                    it   = sbq[q].pop_front();
                    oe_n = (q % 2 == 0) ? a_out_en_n : b_out_en_n;
                    ed   = it.vld & {2{!oe_n}};
                    ex   = '0;
                    for (int l = 0; l < 2; l++) if (ed[l]) ex[l*9 +: 9] = it.word[l*9 +: 9];
                    case (q)
                        0: begin od = p_a_rdata; ov = p_a_drv; end
                        1: begin od = p_b_rdata; ov = p_b_drv; end
                        2: begin od = f_a_rdata; ov = f_a_drv; end
                        default: begin od = f_b_rdata; ov = f_b_drv; end
                    endcase
                    check(ov == ed && od == ex,
                          $sformatf("%s %s", it.req, (q < 2) ? "R4" : "R3"),
                          $sformatf("q%0d drv,data", q), {ov, od}, {ed, ex});
                end
            end
        end
    end

    // Purpose: driver step. It models one edge from the current inputs, queues the expected outputs and advances.
    task automatic tick(input string req);
        logic [7:0]  ea, eb;
        logic [1:0]  wla, wlb, rla, rlb;
        logic [17:0] ra, rb;
        exp_t        it;
        ea  = a_load_n ? ref_hold_a : a_addr;                     // R2
        eb  = b_load_n ? ref_hold_b : b_addr;
        rla = (!a_sel_n && a_sel && a_read)  ? ~{a_hi_n, a_lo_n} : 2'b00;   // R1 R5
        wla = (!a_sel_n && a_sel && !a_read) ? ~{a_hi_n, a_lo_n} : 2'b00;
        rlb = (!b_sel_n && b_sel && b_read)  ? ~{b_hi_n, b_lo_n} : 2'b00;
        wlb = (!b_sel_n && b_sel && !b_read) ? ~{b_hi_n, b_lo_n} : 2'b00;
        ra  = ref_mem[ea];                                        // R8: old data at this edge
        rb  = ref_mem[eb];
        for (int d = 0; d < 2; d++) begin
            it.due = edge_cnt + ((d == 0) ? 2 : 1);
            it.req = req;
            it.vld = rla; it.word = ra; sbq[d*2].push_back(it);
            it.vld = rlb; it.word = rb; sbq[d*2+1].push_back(it);
        end
        if (wla != 2'b00 && wlb != 2'b00 && ea == eb) begin
            coll_cnt++;
            $display("[TB] note: same-edge write collision at address %0d", ea);  // R9
        end
        for (int l = 0; l < 2; l++) begin
            if (wlb[l]) ref_mem[eb][l*9 +: 9] = b_wdata[l*9 +: 9];
            if (wla[l]) ref_mem[ea][l*9 +: 9] = a_wdata[l*9 +: 9];
        end
        ref_hold_a = ea;
        ref_hold_b = eb;
        @(negedge clk);
        #1;
    endtask

    task automatic a_op(input bit on, input bit rd, input logic [7:0] ad, input logic [17:0] wd);
        a_sel_n = !on; a_sel = on; a_read = rd; a_addr = ad; a_wdata = wd;
    endtask

    task automatic b_op(input bit on, input bit rd, input logic [7:0] ad, input logic [17:0] wd);
        b_sel_n = !on; b_sel = on; b_read = rd; b_addr = ad; b_wdata = wd;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++; n_fail++;
            $display("[TB] FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = '0;
        repeat (4) @(negedge clk);
        // R11: outputs idle during and after reset
        check(p_a_drv == 0 && p_b_drv == 0 && f_a_drv == 0 && f_b_drv == 0, "R11", "drv",
              {12'd0, p_a_drv, p_b_drv, f_a_drv, f_b_drv}, 20'd0);
        check(p_a_rdata == 0 && f_b_rdata == 0, "R11", "rdata", {2'b0, p_a_rdata}, 20'd0);
        rst_n = 1'b1;
        #1;
        mon_on = 1'b1;

        // Fill the whole array, both ports writing (R7: no drive while writing)
        for (int i = 0; i < 256; i += 2) begin
            a_op(1, 0, i[7:0], 18'(i * 1031 + 7));
            b_op(1, 0, 8'(i + 1), 18'((i + 1) * 977 + 3));
            tick("R7");
        end

        // Scattered reads on both ports
        for (int i = 0; i < 16; i++) begin
            a_op(1, 1, 8'(i * 37), '0);
            b_op(1, 1, 8'(i * 11 + 5), '0);
            tick("R2");
        end

        // R5: lower-lane-only write, then lane-masked reads
        a_hi_n = 1'b1; a_op(1, 0, 8'd10, 18'h3FFFF); b_op(0, 1, 8'd0, '0); tick("R5");
        a_hi_n = 1'b0; a_op(0, 1, 8'd0, '0);
        b_lo_n = 1'b0; b_hi_n = 1'b1; b_op(1, 1, 8'd10, '0); tick("R5");
        b_lo_n = 1'b1; b_hi_n = 1'b0; tick("R5");
        b_lo_n = 1'b0; b_hi_n = 1'b0; tick("R5");
        a_hi_n = 1'b0; a_lo_n = 1'b1; a_op(1, 0, 8'd11, 18'h15555); b_op(0, 1, 8'd0, '0); tick("R5");
        a_lo_n = 1'b0; a_op(1, 1, 8'd11, '0); tick("R5");

        // R1: each select alone is not enough
        a_op(1, 0, 8'd20, 18'h12345); a_sel_n = 1'b1; tick("R1");
        a_sel_n = 1'b0; a_sel = 1'b0; tick("R1");
        a_op(1, 1, 8'd20, '0); a_sel = 1'b0; tick("R1");
        a_op(1, 1, 8'd20, '0); tick("R1");
        b_op(1, 1, 8'd20, '0); a_op(0, 1, 8'd0, '0); tick("R1");

        // R2: strobe high keeps the previous address
        a_op(1, 1, 8'd30, '0); a_load_n = 1'b0; tick("R2");
        a_op(1, 1, 8'd99, '0); a_load_n = 1'b1; tick("R2");
        a_op(1, 0, 8'd77, 18'h0ABCD); tick("R2");
        a_load_n = 1'b0; a_op(1, 1, 8'd30, '0); tick("R2");
        a_op(1, 1, 8'd99, '0); tick("R2");

        // R6: output enable high floats the port at once
        a_out_en_n = 1'b1; a_op(1, 1, 8'd40, '0); tick("R6");
        tick("R6");
        a_out_en_n = 1'b0; tick("R6");
        tick("R6");

        // R8: cross-port write, same edge sees old, next edge sees new
        a_op(1, 0, 8'd40, 18'h2AAAA); b_op(1, 1, 8'd40, '0); tick("R8");
        a_op(0, 1, 8'd0, '0); tick("R8");
        b_op(1, 0, 8'd41, 18'h1F0F0); a_op(1, 1, 8'd41, '0); tick("R8");
        b_op(0, 1, 8'd0, '0); tick("R8");

        // R9: same-edge writes to one address, A wins
        a_op(1, 0, 8'd50, 18'h00111); b_op(1, 0, 8'd50, 18'h3FEEE); a_hi_n = 1'b1; tick("R9");
        a_hi_n = 1'b0; a_op(1, 1, 8'd50, '0); b_op(1, 1, 8'd50, '0); tick("R9");
        a_op(1, 0, 8'd51, 18'h0C0C0); b_op(1, 0, 8'd51, 18'h30303); tick("R9");
        a_op(1, 1, 8'd51, '0); b_op(0, 1, 8'd0, '0); tick("R9");

        // R10: read then write with output enable low, then with it high
        a_op(1, 1, 8'd60, '0); tick("R10");
        a_op(1, 0, 8'd61, 18'h01234); tick("R10");
        a_op(1, 1, 8'd61, '0); tick("R10");
        a_op(1, 1, 8'd62, '0); tick("R10");
        a_op(1, 0, 8'd63, 18'h04321); a_out_en_n = 1'b1; tick("R10");
        a_op(1, 1, 8'd63, '0); tick("R10");
        a_out_en_n = 1'b0;

        // Drain
        a_op(0, 1, 8'd0, '0); b_op(0, 1, 8'd0, '0);
        repeat (4) tick("R1");

        check(coll_cnt == 2, "R9", "collision count", 20'(coll_cnt), 20'd2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule